// File: doc/BRIEF.md
# Time-Step Master Sequencer

This block is the central controller that paces a fixed-time-step hardware emulation assembled from many independent sub-circuits. After reset it holds everything in an initialization phase of a set length, because the stability of the emulated network depends on the values it starts from. It then repeats one time step after another. Each step first moves data to and from a DAC port, then exchanges data with a host processor port, and finally starts the computation. Both ports are plain request/acknowledge handshakes.

The sub-circuits are split into a nonlinear group and a linear group. Each group has its own start strobe, its own register strobe and a vector of finish flags. A group's inputs may change only when its register strobe fires. That strobe fires only after every finish flag of the group has been seen, counting only flags raised after the group's start pulse. In the default series ordering the nonlinear group runs and is latched before the linear group starts, so the loop delay is one step. A parameter selects the parallel ordering instead. There both groups are started back to back and latched back to back, and each works on the other's values from the previous step, so the loop delay is two steps. With prompt handshakes a series step takes nine clock cycles.

Top module: `ts_sequencer`

## Requirements
- R1: While reset is low and for INIT_CYCLES cycles after it is released, `run_o` is 0, `busy_o` is 1, `step_count_o` is 0 and all requests and strobes are 0. In the next cycle `dac_req_o` goes high.
- R2: `dac_req_o` stays high until a cycle in which `dac_ack_i` is 1. `host_req_o` is high in the following cycle and `dac_req_o` is low by then.
- R3: `host_req_o` stays high until a cycle in which `host_ack_i` is 1. `go_nl_o` pulses in the following cycle.
- R4: Series mode: `latch_nl_o` pulses in the cycle after the last nonlinear finish flag is seen. Flags are taken into account only from the cycle after `go_nl_o`, and a flag that is high during the `go_nl_o` cycle is ignored.
- R5: Series mode: `go_lin_o` pulses in the cycle after `latch_nl_o`. `latch_lin_o` pulses in the cycle after the last linear finish flag is seen, with the same sampling rule as R4.
- R6: A finish flag that was high for only one cycle is remembered until its group's register strobe. The flags of one group may therefore arrive in different cycles.
- R7: Each start and register strobe lasts exactly one cycle, and no two of the four strobes are high in the same cycle.
- R8: In the cycle after `latch_lin_o`, `busy_o` is 0 and `step_count_o` has grown by one, wrapping modulo 2^STEP_W. In the cycle after that, `dac_req_o` and `busy_o` are 1.
- R9: `run_o` is 1 in every cycle from the end of initialization until the next reset.
- R10: Parallel mode: `go_lin_o` pulses in the cycle after `go_nl_o`. Nonlinear flags count from that cycle on. `latch_nl_o` pulses only after both groups have finished, and `latch_lin_o` pulses in the cycle after `latch_nl_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dac_ack_i | input | 1 | DAC transfer acknowledge |
| host_ack_i | input | 1 | Host processor transfer acknowledge |
| fin_nl_i | input | N_NL | Finish flags of the nonlinear sub-circuits |
| fin_lin_i | input | N_LIN | Finish flags of the linear sub-circuits |
| run_o | output | 1 | Global enable, high once initialization is over |
| busy_o | output | 1 | Low only in the one-cycle gap between steps |
| dac_req_o | output | 1 | DAC transfer request |
| host_req_o | output | 1 | Host processor transfer request |
| go_nl_o | output | 1 | Start strobe for the nonlinear group |
| latch_nl_o | output | 1 | Register strobe for the nonlinear group |
| go_lin_o | output | 1 | Start strobe for the linear group |
| latch_lin_o | output | 1 | Register strobe for the linear group |
| step_count_o | output | STEP_W | Completed time steps, wrapping |

## Verification
Every output is decoded from the state register. A result therefore appears exactly one clock edge after the input that causes it: an acknowledge moves the request one cycle later, and a complete set of finish flags brings the register strobe one cycle later. The step count and the low `busy_o` appear one edge after `latch_lin_o`. The bench drives inputs on the falling edge and samples on the next falling edge, so each expected value is read at the single cycle where it is due. Wait loops also confirm, in every cycle of the wait, that nothing moves early. One directed case raises a group's flags during its own start cycle and checks that the register strobe is not issued a cycle early.

// File: rtl/ts_seq_pkg.sv
// Package: shared state encoding for the time-step master sequencer.
// Assumes: nothing; holds types only.
package ts_seq_pkg;

    typedef enum logic [3:0] {
        ST_INIT,       // initialization phase after reset
        ST_DAC,        // DAC handshake
        ST_HOST,       // host processor handshake
        ST_GO_NL,      // start pulse, nonlinear group
        ST_WAIT_NL,    // series: wait for nonlinear finish
        ST_LATCH_NL,   // register pulse, nonlinear group
        ST_GO_LIN,     // start pulse, linear group
        ST_WAIT_LIN,   // series: wait for linear finish
        ST_WAIT_BOTH,  // parallel: wait for both groups
        ST_LATCH_LIN,  // register pulse, linear group
        ST_GAP         // one idle cycle between steps
    } seq_state_t;

endpackage

// File: rtl/ts_init_timer.sv
// Module: ts_init_timer
// Counts the cycles spent in the initialization phase and flags the last one.
// Assumes: run stays high for the whole phase and the phase is entered only
// from reset, so the counter never needs clearing apart from reset.
module ts_init_timer #(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Advance the phase counter while the phase is active.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    // R1: the counter only moves while the phase is active.
    p_init_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> $stable(cnt));
endmodule

// File: rtl/ts_fin_collect.sv
// Module: ts_fin_collect
// Gathers the finish flags of one group of sub-circuits. A flag seen while
// armed is kept until the next clear, so flags may come in different cycles.
// Assumes: clear comes with the group's start pulse, and arm is never high
// in that same cycle, so flags raised with the start pulse are not counted.
module ts_fin_collect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic [WIDTH-1:0] flags,
    output logic             all_done
);
    logic [WIDTH-1:0] seen;

    // Remember every flag seen while armed; forget them all on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) seen <= '0;
        else if (arm)      seen <= seen | flags;
    end

    assign all_done = arm && (&(seen | flags));

    // R4: memory never holds a flag taken in a clear cycle.
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (seen == '0));
    // R6: once seen, a flag stays remembered until cleared.
    p_seen_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr) |=> ((seen & $past(seen)) == $past(seen)));
endmodule

// File: rtl/ts_step_counter.sv
// Module: ts_step_counter
// Counts completed time steps, wrapping at its width.
// Assumes: inc is a single-cycle pulse at the end of each step.
module ts_step_counter #(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [STEP_W-1:0] count
);
    // Add one on each step-end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    // R8: the count only ever moves by one.
    p_count_by_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 1'b1));
endmodule

// File: rtl/ts_sequencer.sv
// Module: ts_sequencer (top)
// Master sequencer for a fixed-time-step emulation: initialization, then per
// step a DAC handshake, a host handshake, and the computation of the
// nonlinear and linear groups, ordered in series (default) or in parallel.
// Assumes: finish flags go high only after their group's start pulse and
// may be pulses or levels; acknowledges are sampled while requests are high.
module ts_sequencer
    import ts_seq_pkg::*;
#(
    parameter int N_NL        = 4,
    parameter int N_LIN       = 4,
    parameter int INIT_CYCLES = 16,
    parameter int STEP_W      = 16,
    parameter bit PARALLEL    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dac_ack_i,
    input  logic              host_ack_i,
    input  logic [N_NL-1:0]   fin_nl_i,
    input  logic [N_LIN-1:0]  fin_lin_i,
    output logic              run_o,
    output logic              busy_o,
    output logic              dac_req_o,
    output logic              host_req_o,
    output logic              go_nl_o,
    output logic              latch_nl_o,
    output logic              go_lin_o,
    output logic              latch_lin_o,
    output logic [STEP_W-1:0] step_count_o
);
    seq_state_t state, state_nx;
    logic init_done, nl_done, lin_done, nl_arm, lin_arm;

    ts_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk(clk), .rst_n(rst_n), .run(state == ST_INIT), .done(init_done));

    // Nonlinear flags count one cycle earlier in parallel mode (during go_lin).
    if (PARALLEL) begin : g_par_arm
        assign nl_arm = (state == ST_GO_LIN) || (state == ST_WAIT_BOTH);
    end else begin : g_ser_arm
        assign nl_arm = (state == ST_WAIT_NL);
    end
    assign lin_arm = (state == ST_WAIT_LIN) || (state == ST_WAIT_BOTH);

    ts_fin_collect #(.WIDTH(N_NL)) u_nl (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_GO_NL), .arm(nl_arm),
        .flags(fin_nl_i), .all_done(nl_done));

    ts_fin_collect #(.WIDTH(N_LIN)) u_lin (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_GO_LIN), .arm(lin_arm),
        .flags(fin_lin_i), .all_done(lin_done));

    ts_step_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(state == ST_LATCH_LIN),
        .count(step_count_o));

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    // Choose the next phase of the step.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:      if (init_done)  state_nx = ST_DAC;
            ST_DAC:       if (dac_ack_i)  state_nx = ST_HOST;
            ST_HOST:      if (host_ack_i) state_nx = ST_GO_NL;
            ST_GO_NL:     state_nx = PARALLEL ? ST_GO_LIN : ST_WAIT_NL;
            ST_WAIT_NL:   if (nl_done)    state_nx = ST_LATCH_NL;
            ST_LATCH_NL:  state_nx = PARALLEL ? ST_LATCH_LIN : ST_GO_LIN;
            ST_GO_LIN:    state_nx = PARALLEL ? ST_WAIT_BOTH : ST_WAIT_LIN;
            ST_WAIT_LIN:  if (lin_done)   state_nx = ST_LATCH_LIN;
            ST_WAIT_BOTH: if (nl_done && lin_done) state_nx = ST_LATCH_NL;
            ST_LATCH_LIN: state_nx = ST_GAP;
            ST_GAP:       state_nx = ST_DAC;
            default:      state_nx = ST_INIT;
        endcase
    end

    // Decode the outputs from the current phase.
    assign run_o       = (state != ST_INIT);
    assign busy_o      = (state != ST_GAP);
    assign dac_req_o   = (state == ST_DAC);
    assign host_req_o  = (state == ST_HOST);
    assign go_nl_o     = (state == ST_GO_NL);
    assign latch_nl_o  = (state == ST_LATCH_NL);
    assign go_lin_o    = (state == ST_GO_LIN);
    assign latch_lin_o = (state == ST_LATCH_LIN);

    // R7: at most one strobe at a time, each a single cycle.
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_nl_o, latch_nl_o, go_lin_o, latch_lin_o}));
    p_go_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_nl_o || go_lin_o) |=> !(go_nl_o && $past(go_nl_o)) && !(go_lin_o && $past(go_lin_o)));
    p_latch_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_nl_o || latch_lin_o) |=> !latch_lin_o || !$past(latch_lin_o));
    // R2: the DAC request holds until acknowledged; the host follows it.
    p_dac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_req_o && !dac_ack_i) |=> dac_req_o);
    p_host_after_dac_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_req_o) |-> $past(dac_req_o && dac_ack_i));
    // R3: processing starts only after the host acknowledge.
    p_go_after_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_nl_o |-> $past(host_req_o && host_ack_i));
    // R4: the nonlinear register strobe needs all nonlinear flags.
    p_latch_nl_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_nl_o |-> $past(nl_done));
    // R5: series ordering, linear starts only after the nonlinear latch.
    p_series_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!PARALLEL && go_lin_o) |-> $past(latch_nl_o));
    p_latch_lin_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!PARALLEL && latch_lin_o) |-> $past(lin_done));
    // R8: one idle cycle after the linear latch.
    p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_lin_o |=> !busy_o);
    // R9: the global enable never drops outside reset.
    p_run_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> run_o);
    // R10: parallel mode starts both groups back to back, latches after both.
    p_par_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (PARALLEL && go_nl_o) |=> go_lin_o);
    p_par_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (PARALLEL && latch_nl_o) |-> $past(lin_done));
endmodule

// File: tb/ts_sequencer_tb.sv
// Bench for ts_sequencer: a series instance walked through a table of step
// vectors, then directed tests for reset, early flags and parallel mode.
module ts_sequencer_tb;
    localparam int NNL = 2;
    localparam int NLN = 3;
    localparam int INITC = 4;
    localparam int SW = 3;

    localparam logic [NNL-1:0] NL_ALL  = '1;
    localparam logic [NNL-1:0] NL_REST = NL_ALL & ~NNL'(1);
    localparam logic [NLN-1:0] LN_ALL  = '1;
    localparam logic [NLN-1:0] LN_REST = LN_ALL & ~NLN'(1);

    // Per step: DAC ack delay, host ack delay, nonlinear finish cycle, linear finish cycle.
    localparam int NV = 9;
    localparam int VEC [0:NV-1][0:3] = '{
        '{0, 0, 1, 1}, '{2, 0, 1, 1}, '{0, 3, 1, 1},
        '{0, 0, 3, 1}, '{0, 0, 1, 4}, '{1, 1, 2, 2},
        '{4, 2, 5, 3}, '{0, 1, 6, 1}, '{3, 0, 2, 5}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dac_ack = 1'b0, host_ack = 1'b0;
    logic [NNL-1:0] fin_nl = '0;
    logic [NLN-1:0] fin_lin = '0;
    logic run, busy, dac_req, host_req, go_nl, latch_nl, go_lin, latch_lin;
    logic [SW-1:0] cnt;

    logic p_dac_ack = 1'b0, p_host_ack = 1'b0;
    logic [NNL-1:0] p_fin_nl = '0;
    logic [NLN-1:0] p_fin_lin = '0;
    logic p_run, p_busy, p_dac_req, p_host_req, p_go_nl, p_latch_nl, p_go_lin, p_latch_lin;
    logic [SW-1:0] p_cnt;

    int n_chk = 0, n_fail = 0;
    logic [SW-1:0] exp_cnt = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ts_sequencer #(.N_NL(NNL), .N_LIN(NLN), .INIT_CYCLES(INITC), .STEP_W(SW),
                   .PARALLEL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .dac_ack_i(dac_ack), .host_ack_i(host_ack),
        .fin_nl_i(fin_nl), .fin_lin_i(fin_lin), .run_o(run), .busy_o(busy),
        .dac_req_o(dac_req), .host_req_o(host_req), .go_nl_o(go_nl),
        .latch_nl_o(latch_nl), .go_lin_o(go_lin), .latch_lin_o(latch_lin),
        .step_count_o(cnt));

    ts_sequencer #(.N_NL(NNL), .N_LIN(NLN), .INIT_CYCLES(INITC), .STEP_W(SW),
                   .PARALLEL(1'b1)) u_par (
        .clk(clk), .rst_n(rst_n), .dac_ack_i(p_dac_ack), .host_ack_i(p_host_ack),
        .fin_nl_i(p_fin_nl), .fin_lin_i(p_fin_lin), .run_o(p_run), .busy_o(p_busy),
        .dac_req_o(p_dac_req), .host_req_o(p_host_req), .go_nl_o(p_go_nl),
        .latch_nl_o(p_latch_nl), .go_lin_o(p_go_lin), .latch_lin_o(p_latch_lin),
        .step_count_o(p_cnt));

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // R1: initialization phase after reset release, then the first DAC request.
    task automatic chk_init();
        for (int i = 0; i < INITC; i++) begin
            chk("R1 run low in init", run, 0);
            chk("R1 busy high in init", busy, 1);
            chk("R1 no dac request in init", dac_req, 0);
            chk("R1 no strobe in init", int'(go_nl | latch_nl | go_lin | latch_lin), 0);
            chk("R1 step count zero", cnt, 0);
            tick();
        end
        chk("R1 dac request after init", dac_req, 1);
        chk("R9 run after init", run, 1);
        chk("R1 parallel dac request after init", p_dac_req, 1);
    endtask

    // One series step; the bench is at a falling edge in the DAC phase.
    task automatic step_s(input int dl, input int hl, input int nd, input int ld,
                          input bit early);
        chk("R2 dac request at step start", dac_req, 1);
        chk("R9 run held", run, 1);
        for (int i = 0; i < dl; i++) begin
            tick();
            chk("R2 dac request held", dac_req, 1);
            chk("R3 host idle during dac", host_req, 0);
        end
        dac_ack = 1'b1; tick(); dac_ack = 1'b0;
        chk("R2 host request after dac ack", host_req, 1);
        chk("R2 dac request dropped", dac_req, 0);
        for (int i = 0; i < hl; i++) begin
            tick();
            chk("R3 host request held", host_req, 1);
            chk("R3 no start before host ack", go_nl, 0);
        end
        host_ack = 1'b1; tick(); host_ack = 1'b0;
        chk("R3 go_nl after host ack", go_nl, 1);
        if (early) fin_nl = NL_ALL;
        tick(); fin_nl = '0;
        chk("R7 go_nl single cycle", go_nl, 0);
        for (int i = 1; i < nd; i++) begin
            if (i == 1) fin_nl = NNL'(1);
            tick(); fin_nl = '0;
            chk(early ? "R4 flags in start cycle ignored" : "R6 partial nl flags wait",
                latch_nl, 0);
        end
        fin_nl = (nd > 1) ? NL_REST : NL_ALL;
        tick(); fin_nl = '0;
        chk("R4 latch_nl after all nl done", latch_nl, 1);
        tick();
        chk("R5 go_lin after latch_nl", go_lin, 1);
        chk("R7 latch_nl single cycle", latch_nl, 0);
        tick();
        chk("R7 go_lin single cycle", go_lin, 0);
        for (int i = 1; i < ld; i++) begin
            if (i == 1) fin_lin = NLN'(1);
            tick(); fin_lin = '0;
            chk("R6 partial lin flags wait", latch_lin, 0);
        end
        fin_lin = (ld > 1) ? LN_REST : LN_ALL;
        tick(); fin_lin = '0;
        chk("R5 latch_lin after all lin done", latch_lin, 1);
        tick();
        exp_cnt = exp_cnt + 1'b1;
        chk("R8 busy low in gap", busy, 0);
        chk("R8 step count advanced", cnt, exp_cnt);
        tick();
        chk("R8 next step begins", dac_req, 1);
        chk("R8 busy high again", busy, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        chk_init();

        // Table-driven series steps; nine steps also wrap the 3-bit count.
        for (int v = 0; v < NV; v++)
            step_s(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);

        // R4: flags raised during the start cycle itself must not count.
        step_s(0, 0, 2, 1, 1'b1);

        // R1: reset in mid-run returns to the initialization phase.
        rst_n = 1'b0; tick(); tick();
        chk("R1 count cleared by reset", cnt, 0);
        chk("R1 run low in reset", run, 0);
        chk("R1 busy high in reset", busy, 1);
        rst_n = 1'b1;
        exp_cnt = '0;
        chk_init();

        // R10: parallel ordering on the second instance.
        chk("R10 parallel dac request", p_dac_req, 1);
        p_dac_ack = 1'b1; tick(); p_dac_ack = 1'b0;
        chk("R10 parallel host request", p_host_req, 1);
        p_host_ack = 1'b1; tick(); p_host_ack = 1'b0;
        chk("R10 parallel go_nl", p_go_nl, 1);
        tick();
        chk("R10 parallel go_lin right after go_nl", p_go_lin, 1);
        chk("R7 parallel go_nl single cycle", p_go_nl, 0);
        p_fin_nl = NL_ALL;
        tick(); p_fin_nl = '0;
        chk("R10 no latch while linear busy", p_latch_nl, 0);
        tick();
        chk("R10 still waiting for linear", p_latch_nl, 0);
        p_fin_lin = LN_ALL;
        tick(); p_fin_lin = '0;
        chk("R10 latch_nl after both done", p_latch_nl, 1);
        tick();
        chk("R10 latch_lin after latch_nl", p_latch_lin, 1);
        tick();
        chk("R8 parallel gap", p_busy, 0);
        chk("R8 parallel step count", p_cnt, 1);

        // The series instance is still waiting in its DAC phase.
        chk("R2 series dac request held while idle", dac_req, 1);
        finish_run();
    end
endmodule